// File: doc/BRIEF.md
# Speculative Register Producer Table

This block records, for every architectural register, which in-flight instruction will write the register's next value. An out-of-order front end uses it at decode. Up to three source registers are looked up combinationally against the table of the current speculation level. A source whose entry is empty reads the architected register file and is ready. A source whose entry holds a producer waits on that producer's tag and output slot. At the same clock edge, up to two destination registers of the decoded instruction are recorded with its tag. The lookups see the table as it was before that edge, so an instruction never waits on itself.

Each speculation level keeps its own full copy of the table. There is one more level than the branch queue has entries. When a branch opens a new level, the current table, including the installs made in that cycle, is copied into the next level. When a producer completes, its entry is removed at the producer's own level. The removal then continues upward through each deeper level up to the current one, and stops at the first level whose entry names a different producer. A recovery command makes a shallower level current. An exception flush empties level 0.

Top module: `spec_rename_table`

## Requirements
- R1: After reset the current level is 0 and every entry at every level is empty, so every lookup reports ready.
- R2: A source flagged as having no register is reported ready, whatever the table holds for the register number presented.
- R3: A source whose entry at the current level is empty is reported ready. A source whose entry is valid is reported not ready, together with the entry's producer tag and output slot. Slot 0 is the first destination of the producer and slot 1 the second.
- R4: An install takes effect at the next clock edge, so a lookup in the same cycle sees the old entry. If both destination slots name the same register, slot 1 is recorded.
- R5: A level push writes the current table, with this cycle's installs and completion applied, into the next level and increments the current level. A push at the deepest level (the branch queue depth) is ignored.
- R6: A completion carrying tag, slot, register and producer level clears the matching entry at the producer level. It then clears the entry at each deeper level up to the current one, stopping at the first level whose entry is empty or names a different tag or slot.
- R7: When an install and a completion hit the same entry in one cycle, the install wins.
- R8: A recovery makes the given level current at the next edge. Installs and pushes presented in the same cycle are discarded; a completion in the same cycle still applies.
- R9: An exception flush empties every entry of level 0 and leaves other levels and the current level unchanged. It takes priority over any install or copy into level 0 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_none | input | 3 | Per source: 1 means the source uses no register |
| src_reg | input | 3*RW | Source register numbers, source i in bits [i*RW +: RW] |
| src_ready | output | 3 | Per source: operand readable from the architected file |
| src_tag | output | 3*TAGW | Producer tag per source, valid when not ready |
| src_slot | output | 3 | Producer output slot per source, valid when not ready |
| dst_we | input | 2 | Install enable for destination slots 0 and 1 |
| dst_reg | input | 2*RW | Destination register numbers, slot d in bits [d*RW +: RW] |
| dst_tag | input | TAGW | Tag of the instruction being decoded |
| lvl_push | input | 1 | Open a new speculation level |
| cmp_valid | input | 1 | A producer completes |
| cmp_tag | input | TAGW | Completing producer tag |
| cmp_slot | input | 1 | Completing output slot |
| cmp_reg | input | RW | Register written by the completing output |
| cmp_lvl | input | LVW | Speculation level the producer was decoded at |
| rcv_valid | input | 1 | Recover to a shallower level |
| rcv_lvl | input | LVW | Level to make current, at most the current one |
| exc_clr | input | 1 | Exception flush of level 0 |
| cur_lvl | output | LVW | Current speculation level |

## Verification
Every cycle, the assertions check that the level stays in range and steps by one on a push. They also check that recovery lands on the requested level, that an exception leaves level 0 empty, that a new install is present the cycle after, that a push makes the new level equal to its parent, and that a matching completion removes its entry at the producer level. Only the bench's scenarios can show the upward walk and where it stops, that copies above a stopped walk keep stale producers until recovery, that same-cycle lookups do not see the instruction's own installs, and the priority between install, completion, recovery and flush, all observed through later lookups.

// File: rtl/spec_rename_table.sv
module spec_rename_table #(
  parameter int NREG      = 32,
  parameter int TAGW      = 6,
  parameter int BRQ_DEPTH = 4,
  localparam int RW   = $clog2(NREG),
  localparam int NLEV = BRQ_DEPTH + 1,
  localparam int LVW  = $clog2(NLEV)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        src_none,
  input  logic [3*RW-1:0]   src_reg,
  output logic [2:0]        src_ready,
  output logic [3*TAGW-1:0] src_tag,
  output logic [2:0]        src_slot,
  input  logic [1:0]        dst_we,
  input  logic [2*RW-1:0]   dst_reg,
  input  logic [TAGW-1:0]   dst_tag,
  input  logic              lvl_push,
  input  logic              cmp_valid,
  input  logic [TAGW-1:0]   cmp_tag,
  input  logic              cmp_slot,
  input  logic [RW-1:0]     cmp_reg,
  input  logic [LVW-1:0]    cmp_lvl,
  input  logic              rcv_valid,
  input  logic [LVW-1:0]    rcv_lvl,
  input  logic              exc_clr,
  output logic [LVW-1:0]    cur_lvl
);
  localparam int EW = TAGW + 2;
  localparam logic [LVW-1:0] TOP = LVW'(NLEV - 1);

  // entry: {valid, tag, slot}
  logic [NLEV-1:0][NREG-1:0][EW-1:0] tbl;
  logic [NREG-1:0][EW-1:0]           row;
  logic [LVW-1:0]                    cur;
  logic [NLEV-1:0]                   clr;

  assign cur_lvl = cur;

  for (genvar i = 0; i < 3; i++) begin : g_src
    logic [EW-1:0] e;
    assign e = tbl[cur][src_reg[i*RW +: RW]];
    assign src_ready[i] = src_none[i] | ~e[EW-1];
    assign src_tag[i*TAGW +: TAGW] = e[EW-2:1];
    assign src_slot[i] = e[0];
  end

  always_comb begin
    logic alive;
    alive = 1'b1;
    clr = '0;
    for (int l = 0; l < NLEV; l++) begin
      if (cmp_valid && LVW'(l) >= cmp_lvl && LVW'(l) <= cur) begin
        if (alive && tbl[l][cmp_reg] == {1'b1, cmp_tag, cmp_slot}) clr[l] = 1'b1;
        else alive = 1'b0;
      end
    end
  end

  always_comb begin
    row = tbl[cur];
    if (clr[cur]) row[cmp_reg][EW-1] = 1'b0;
    for (int d = 0; d < 2; d++)
      if (dst_we[d]) row[dst_reg[d*RW +: RW]] = {1'b1, dst_tag, 1'(d)};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tbl <= '0;
      cur <= '0;
    end else begin
      for (int l = 0; l < NLEV; l++)
        if (clr[l]) tbl[l][cmp_reg][EW-1] <= 1'b0;
      if (rcv_valid) begin
        cur <= rcv_lvl;
      end else begin
        tbl[cur] <= row;
        if (lvl_push && cur != TOP) begin
          tbl[cur + 1'b1] <= row;
          cur <= cur + 1'b1;
        end
      end
      if (exc_clr) tbl[0] <= '0;
    end
  end

  p_lvl_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cur <= TOP);

  p_push_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_push && !rcv_valid && cur != TOP |=> cur == $past(cur) + 1'b1);

  p_push_copy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_push && !rcv_valid && !exc_clr && cur != TOP |=> tbl[cur] == tbl[cur - 1'b1]);

  p_rcv_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rcv_valid |=> cur == $past(rcv_lvl));

  p_exc_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    exc_clr |=> tbl[0] == '0);

  p_install_seen_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dst_we[0] && !rcv_valid && !exc_clr &&
    !(dst_we[1] && dst_reg[2*RW-1:RW] == dst_reg[RW-1:0])
    |=> tbl[$past(cur)][$past(dst_reg[RW-1:0])] == {1'b1, $past(dst_tag), 1'b0});

  p_cmp_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_valid && cmp_lvl <= cur && !rcv_valid && !exc_clr && dst_we == 2'b00 && !lvl_push &&
    tbl[cmp_lvl][cmp_reg] == {1'b1, cmp_tag, cmp_slot}
    |=> !tbl[$past(cmp_lvl)][$past(cmp_reg)][EW-1]);
endmodule

// File: tb/spec_rename_table_bench.sv
module spec_rename_table_bench;
  localparam int NREG = 32, TAGW = 6, BRQ = 4;
  localparam int RW = 5, NLEV = BRQ + 1, LVW = 3;

  logic clk = 0, rst_n = 0;
  logic [2:0] src_none, src_ready, src_slot;
  logic [3*RW-1:0] src_reg;
  logic [3*TAGW-1:0] src_tag;
  logic [1:0] dst_we;
  logic [2*RW-1:0] dst_reg;
  logic [TAGW-1:0] dst_tag, cmp_tag;
  logic lvl_push, cmp_valid, cmp_slot, rcv_valid, exc_clr;
  logic [RW-1:0] cmp_reg;
  logic [LVW-1:0] cmp_lvl, rcv_lvl, cur_lvl;

  spec_rename_table #(.NREG(NREG), .TAGW(TAGW), .BRQ_DEPTH(BRQ)) u_spec_rename_table (.*);

  always #2 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;
  bit mv [NLEV][NREG];
  int mt [NLEV][NREG];
  bit ms [NLEV][NREG];
  int mcur;

  task automatic chk(string rq, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  task automatic idle();
    src_none = 0; src_reg = 0; dst_we = 0; dst_reg = 0; dst_tag = 0;
    lvl_push = 0; cmp_valid = 0; cmp_tag = 0; cmp_slot = 0; cmp_reg = 0;
    cmp_lvl = 0; rcv_valid = 0; rcv_lvl = 0; exc_clr = 0;
  endtask

  task automatic look(int a, int b, int c);
    src_reg = {RW'(c), RW'(b), RW'(a)};
  endtask

  function automatic void model_step();
    bit alive = 1;
    bit cv [NREG]; int ct [NREG]; bit cs [NREG];
    for (int l = 0; l < NLEV; l++)
      if (cmp_valid && l >= int'(cmp_lvl) && l <= mcur) begin
        if (alive && mv[l][cmp_reg] && mt[l][cmp_reg] == int'(cmp_tag) && ms[l][cmp_reg] == cmp_slot)
          mv[l][cmp_reg] = 0;
        else alive = 0;
      end
    if (rcv_valid) mcur = int'(rcv_lvl);
    else begin
      for (int d = 0; d < 2; d++)
        if (dst_we[d]) begin
          mv[mcur][dst_reg[d*RW +: RW]] = 1;
          mt[mcur][dst_reg[d*RW +: RW]] = int'(dst_tag);
          ms[mcur][dst_reg[d*RW +: RW]] = d[0];
        end
      if (lvl_push && mcur < NLEV - 1) begin
        for (int r = 0; r < NREG; r++) begin
          cv[r] = mv[mcur][r]; ct[r] = mt[mcur][r]; cs[r] = ms[mcur][r];
        end
        mcur++;
        for (int r = 0; r < NREG; r++) begin
          mv[mcur][r] = cv[r]; mt[mcur][r] = ct[r]; ms[mcur][r] = cs[r];
        end
      end
    end
    if (exc_clr) for (int r = 0; r < NREG; r++) mv[0][r] = 0;
  endfunction

  // inputs already driven after a negedge; check the lookups, then advance one edge
  task automatic step(string rq);
    #1;
    chk(rq, "cur_lvl", int'(cur_lvl), mcur);
    for (int i = 0; i < 3; i++) begin
      int r = int'(src_reg[i*RW +: RW]);
      bit er = src_none[i] || !mv[mcur][r];
      chk(rq, $sformatf("ready[%0d]", i), int'(src_ready[i]), int'(er));
      if (!er) begin
        chk(rq, $sformatf("tag[%0d]", i), int'(src_tag[i*TAGW +: TAGW]), mt[mcur][r]);
        chk(rq, $sformatf("slot[%0d]", i), int'(src_slot[i]), int'(ms[mcur][r]));
      end
    end
    model_step();
    @(negedge clk);
    idle();
  endtask

  initial begin
    #800000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    idle();
    mcur = 0;
    for (int l = 0; l < NLEV; l++) for (int r = 0; r < NREG; r++) mv[l][r] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    look(0, 5, 31); step("R1");
    // R4 install not visible in same cycle; slots 0 and 1
    look(5, 7, 5); dst_we = 2'b11; dst_reg = {RW'(7), RW'(5)}; dst_tag = 9; step("R4");
    // R3 valid entries; R2 none flag masks a valid entry
    look(5, 7, 5); src_none = 3'b100; step("R3");
    look(5, 7, 5); src_none = 3'b111; step("R2");
    // R4 same register on both slots -> slot 1
    dst_we = 2'b11; dst_reg = {RW'(10), RW'(10)}; dst_tag = 3; step("R4");
    look(10, 1, 2); step("R4");
    // R5 push with install, copies into level 1
    dst_we = 2'b01; dst_reg = RW'(12); dst_tag = 4; lvl_push = 1; step("R5");
    look(12, 5, 7); lvl_push = 1; step("R5");
    dst_we = 2'b01; dst_reg = RW'(5); dst_tag = 11; lvl_push = 1; step("R5");
    look(5, 12, 10); lvl_push = 1; step("R5");
    look(5, 12, 7); lvl_push = 1; step("R5");   // at deepest: ignored
    look(5, 12, 7); step("R5");
    // R6 walk from level 0 stops at level 2 (new producer of r5)
    cmp_valid = 1; cmp_tag = 9; cmp_slot = 0; cmp_reg = 5; cmp_lvl = 0; step("R6");
    look(5, 7, 12); step("R6");
    // R8 recover to 1 discards push and install
    rcv_valid = 1; rcv_lvl = 1; lvl_push = 1; dst_we = 2'b01; dst_reg = RW'(20); dst_tag = 30; step("R8");
    look(5, 20, 12); step("R8");
    rcv_valid = 1; rcv_lvl = 0; step("R8");
    look(5, 7, 20); step("R6");
    // R7 install beats completion on same entry
    cmp_valid = 1; cmp_tag = 9; cmp_slot = 1; cmp_reg = 7; cmp_lvl = 0;
    dst_we = 2'b01; dst_reg = RW'(7); dst_tag = 21; step("R7");
    look(7, 10, 12); step("R7");
    // R9 flush clears level 0 only
    lvl_push = 1; step("R9");
    exc_clr = 1; look(7, 10, 12); step("R9");
    look(7, 10, 12); step("R9");
    rcv_valid = 1; rcv_lvl = 0; step("R9");
    look(7, 10, 12); step("R9");
    // random mix
    for (int n = 0; n < 4000; n++) begin
      int lv, rg;
      src_none = 3'($urandom);
      look($urandom % 8, $urandom % 8, $urandom % 8);
      dst_we = 2'($urandom);
      dst_reg = {RW'($urandom % 8), RW'($urandom % 8)};
      dst_tag = TAGW'($urandom);
      lvl_push = ($urandom % 4) == 0;
      if ($urandom % 2) begin
        lv = $urandom % (mcur + 1); rg = $urandom % 8;
        cmp_valid = 1; cmp_lvl = LVW'(lv); cmp_reg = RW'(rg);
        if (mv[lv][rg] && ($urandom % 4) != 0) begin
          cmp_tag = TAGW'(mt[lv][rg]); cmp_slot = ms[lv][rg];
        end else begin
          cmp_tag = TAGW'($urandom); cmp_slot = 1'($urandom);
        end
      end
      rcv_valid = ($urandom % 12) == 0;
      rcv_lvl = LVW'($urandom % (mcur + 1));
      exc_clr = ($urandom % 40) == 0;
      step("R3");
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule